// File: doc/BRIEF.md
# PLL Control and Configuration Register Block

This block is the software-visible face of a clock generator's phase-locked loop. It stores the reference divider setting and the VCO range (multiply) setting that the loop consumes, together with a handful of control bits: loop enable, VCO base-clock select, automatic lock tracking and interrupt enable. A CPU reaches it through a plain 8-bit register bus, and the loop reaches it through a lock indication input.

The block guards the loop against unsafe reprogramming. While the loop is enabled, the divider and range settings cannot change. The VCO cannot become the base clock while the range setting is zero. When automatic tracking is on, every change of the lock indication, in either direction, raises a sticky flag. An interrupt request is raised only when interrupts are also enabled. Software clears the flag by reading the control register.

Register map: the control register is at address 0, the tracking register at 1, the range register at 2 and the divider register at 3. All other addresses are unmapped.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset, the range register reads 0x40 and drives `range_o` with 64. The divider register reads 0x01 and drives `refdiv_o` with 1. The control and tracking registers read 0x00, and `irq_o`, `loop_en_o` and `vco_sel_o` are 0.
- R2: A write to address 3 loads bits 3..0 into the divider field only while the loop enable is 0, and is ignored while it is 1. Bits 7..4 of address 3 always read 0.
- R3: A write to address 2 loads all 8 bits into the range field only while the loop enable is 0, and is ignored while it is 1.
- R4: Writing 1 to the VCO select bit (address 0, bit 4) is refused, and the bit keeps its value, while the range field is zero. Writing 0 to it always clears it.
- R5: While automatic tracking (address 1, bit 7) is 1, every rising or falling change of `lock_i` sets the lock-change flag (address 0, bit 6) once it has passed a two-stage synchronizer.
- R6: While automatic tracking is 0, changes of `lock_i` leave the flag unchanged.
- R7: The flag sets whatever the interrupt enable (address 0, bit 7) holds. `irq_o` is 1 exactly when both the flag and the interrupt enable are 1.
- R8: A bus read of address 0 clears the flag after returning its value. Bus writes cannot change the flag. A lock change that sets the flag in the same cycle as the clearing read leaves the flag set.
- R9: Reads of unmapped addresses return 0x00, and writes to them change no register.
- R10: The loop enable (address 0, bit 5) and the VCO select bit are read back at their positions and drive `loop_en_o` and `vco_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| lock_i | input | 1 | Lock indication from the loop, asynchronous |
| irq_o | output | 1 | Interrupt request |
| loop_en_o | output | 1 | Loop enable to the analog loop |
| vco_sel_o | output | 1 | Selects the VCO as base clock |
| range_o | output | RANGE_W | VCO range (multiply) setting |
| refdiv_o | output | DIV_W | Reference divider setting |

## Verification
The bench uses the default parameters: a 4-bit address, an 8-bit range field reset to 64, a 4-bit divider field reset to 1, and a two-stage synchronizer. The 4-bit address leaves twelve unmapped locations to probe. The non-zero range reset lets the VCO select be accepted straight after reset, so the bench first writes the range to zero to reach the refusal case. The fixed two-stage latency lets the bench place a clearing read in exactly the cycle in which a lock edge sets the flag.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

    localparam int DATA_W = 8;

    // register addresses; software depends on these
    localparam int ADR_CTRL  = 0;
    localparam int ADR_TRACK = 1;
    localparam int ADR_RANGE = 2;
    localparam int ADR_DIV   = 3;

    // bit positions inside the control and tracking registers
    localparam int CTL_IE_BIT   = 7;
    localparam int CTL_FLAG_BIT = 6;
    localparam int CTL_ON_BIT   = 5;
    localparam int CTL_VCO_BIT  = 4;
    localparam int TRK_AUTO_BIT = 7;

    typedef struct packed {
        logic irq_en;
        logic loop_en;
        logic vco_sel;
        logic auto_en;
    } ctl_bits_t;

endpackage

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_i,
    output logic edge_o
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;

    always_comb begin
        sync_d[0] = lock_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
        prev_d = sync_q[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign edge_o = sync_q[MSB] ^ prev_q;

endmodule

// File: rtl/pll_lock_flag.sv
module pll_lock_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic auto_i,
    input  logic clr_i,
    input  logic irq_en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_d, flag_q;
    logic set_w;

    always_comb begin
        set_w  = edge_i & auto_i;
        // a new edge wins over a clearing read in the same cycle
        flag_d = set_w | (flag_q & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & irq_en_i;

    AST_FLAG_SETS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && auto_i) |=> flag_q); // R5

    AST_FLAG_QUIET_NO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_i && !flag_q) |=> !flag_q); // R6

    AST_FLAG_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(edge_i && auto_i)) |=> !flag_q); // R8

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
    import pll_ctl_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int RANGE_W   = 8,
    parameter int DIV_W     = 4,
    parameter int RANGE_RST = 64,
    parameter int DIV_RST   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic                flag_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                clr_flag_o,
    output ctl_bits_t           ctl_o,
    output logic [RANGE_W-1:0]  range_o,
    output logic [DIV_W-1:0]    div_o
);
    typedef struct packed {
        ctl_bits_t          ctl;
        logic [RANGE_W-1:0] range;
        logic [DIV_W-1:0]   div;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_ctrl, hit_track, hit_range, hit_div;

    always_comb begin
        hit_ctrl  = (addr_i == ADDR_W'(ADR_CTRL));
        hit_track = (addr_i == ADDR_W'(ADR_TRACK));
        hit_range = (addr_i == ADDR_W'(ADR_RANGE));
        hit_div   = (addr_i == ADDR_W'(ADR_DIV));
    end

    // next-state: writes gated by the loop-state interlocks
    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            if (hit_ctrl) begin
                regs_d.ctl.irq_en  = wdata_i[CTL_IE_BIT];
                regs_d.ctl.loop_en = wdata_i[CTL_ON_BIT];
                if (!wdata_i[CTL_VCO_BIT]) begin
                    regs_d.ctl.vco_sel = 1'b0;
                end else if (regs_q.range != '0) begin
                    regs_d.ctl.vco_sel = 1'b1;
                end
            end
            if (hit_track) begin
                regs_d.ctl.auto_en = wdata_i[TRK_AUTO_BIT];
            end
            if (hit_range && !regs_q.ctl.loop_en) begin
                regs_d.range = wdata_i[RANGE_W-1:0];
            end
            if (hit_div && !regs_q.ctl.loop_en) begin
                regs_d.div = wdata_i[DIV_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.range <= RANGE_W'(RANGE_RST);
            regs_q.div   <= DIV_W'(DIV_RST);
        end else begin
            regs_q <= regs_d;
        end
    end

    // read return path
    always_comb begin
        rdata_o = '0;
        if (hit_ctrl) begin
            rdata_o[CTL_IE_BIT]   = regs_q.ctl.irq_en;
            rdata_o[CTL_FLAG_BIT] = flag_i;
            rdata_o[CTL_ON_BIT]   = regs_q.ctl.loop_en;
            rdata_o[CTL_VCO_BIT]  = regs_q.ctl.vco_sel;
        end else if (hit_track) begin
            rdata_o[TRK_AUTO_BIT] = regs_q.ctl.auto_en;
        end else if (hit_range) begin
            rdata_o[RANGE_W-1:0] = regs_q.range;
        end else if (hit_div) begin
            rdata_o[DIV_W-1:0] = regs_q.div;
        end
    end

    assign clr_flag_o = rd_en_i & hit_ctrl;
    assign ctl_o      = regs_q.ctl;
    assign range_o    = regs_q.range;
    assign div_o      = regs_q.div;

    AST_DIV_FROZEN_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctl.loop_en |=> $stable(regs_q.div)); // R2

    AST_RANGE_FROZEN_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.ctl.loop_en |=> $stable(regs_q.range)); // R3

    AST_VCO_NEEDS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.ctl.vco_sel && regs_q.range == '0) |=> !regs_q.ctl.vco_sel); // R4

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_ctl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int RANGE_W     = 8,
    parameter int DIV_W       = 4,
    parameter int RANGE_RST   = 64,
    parameter int DIV_RST     = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [7:0]         wdata_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    output logic [7:0]         rdata_o,
    input  logic               lock_i,
    output logic               irq_o,
    output logic               loop_en_o,
    output logic               vco_sel_o,
    output logic [RANGE_W-1:0] range_o,
    output logic [DIV_W-1:0]   refdiv_o
);
    ctl_bits_t ctl_w;
    logic      edge_w;
    logic      flag_w;
    logic      clr_w;

    pll_lock_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_lock_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_i (lock_i),
        .edge_o (edge_w)
    );

    pll_lock_flag i_lock_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .edge_i   (edge_w),
        .auto_i   (ctl_w.auto_en),
        .clr_i    (clr_w),
        .irq_en_i (ctl_w.irq_en),
        .flag_o   (flag_w),
        .irq_o    (irq_o)
    );

    pll_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .RANGE_W   (RANGE_W),
        .DIV_W     (DIV_W),
        .RANGE_RST (RANGE_RST),
        .DIV_RST   (DIV_RST)
    ) i_cfg_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .flag_i     (flag_w),
        .rdata_o    (rdata_o),
        .clr_flag_o (clr_w),
        .ctl_o      (ctl_w),
        .range_o    (range_o),
        .div_o      (refdiv_o)
    );

    assign loop_en_o = ctl_w.loop_en;
    assign vco_sel_o = ctl_w.vco_sel;

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_w.irq_en) |-> !irq_o); // R7

endmodule

// File: tb/test_pll_ctl_regs.sv
module test_pll_ctl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       lock = 1'b0;
    logic       irq;
    logic       loop_en;
    logic       vco_sel;
    logic [7:0] range_v;
    logic [3:0] refdiv;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [3:0] A_CTRL = 4'd0, A_TRK = 4'd1, A_RNG = 4'd2, A_DIV = 4'd3;
    localparam logic [7:0] B_IE = 8'h80, B_FLAG = 8'h40, B_ON = 8'h20, B_VCO = 8'h10;
    localparam logic [7:0] B_AUTO = 8'h80;

    always #10 clk = ~clk;

    pll_ctl_regs i_pll_ctl_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .rdata_o   (rdata),
        .lock_i    (lock),
        .irq_o     (irq),
        .loop_en_o (loop_en),
        .vco_sel_o (vco_sel),
        .range_o   (range_v),
        .refdiv_o  (refdiv)
    );

    typedef struct {
        logic [3:0] a;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: compares read data while the strobe is high
    always @(negedge clk) begin
        if (rd_en) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL scoreboard: unexpected read, actual 0x%02h expected none", rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (rdata !== it.exp || addr !== it.a) begin
                    n_fail++;
                    $display("FAIL %s: addr %0d actual 0x%02h expected 0x%02h",
                             it.tag, addr, rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.a = a; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL scoreboard: %0d reads left, expected 0", sb_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(range_v, 8'd64, "R1 range_o");
        chk({4'h0, refdiv}, 8'd1, "R1 refdiv_o");
        chk({5'b0, irq, loop_en, vco_sel}, 8'h00, "R1 irq/loop/vco");
        rd_expect(A_CTRL, 8'h00, "R1 ctrl");
        rd_expect(A_TRK,  8'h00, "R1 track");
        rd_expect(A_RNG,  8'h40, "R1 range");
        rd_expect(A_DIV,  8'h01, "R1 div");

        // R2 divider write, upper bits read zero
        wr(A_DIV, 8'hF5);
        rd_expect(A_DIV, 8'h05, "R2 div write");
        chk({4'h0, refdiv}, 8'h05, "R2 refdiv_o");

        // R4 VCO select refused with zero range
        wr(A_RNG, 8'h00);
        wr(A_CTRL, B_VCO);
        rd_expect(A_CTRL, 8'h00, "R4 vco refused");
        chk({7'b0, vco_sel}, 8'h00, "R4 vco_sel_o");
        wr(A_RNG, 8'h22);
        wr(A_CTRL, B_VCO);
        rd_expect(A_CTRL, B_VCO, "R4 vco accepted");
        chk({7'b0, vco_sel}, 8'h01, "R10 vco_sel_o");

        // R2/R3 interlock while loop enabled
        wr(A_CTRL, B_ON | B_VCO);
        chk({7'b0, loop_en}, 8'h01, "R10 loop_en_o");
        rd_expect(A_CTRL, B_ON | B_VCO, "R10 ctrl readback");
        wr(A_DIV, 8'h09);
        rd_expect(A_DIV, 8'h05, "R2 div frozen");
        wr(A_RNG, 8'h33);
        rd_expect(A_RNG, 8'h22, "R3 range frozen");
        chk(range_v, 8'h22, "R3 range_o");
        wr(A_CTRL, 8'h00);
        wr(A_RNG, 8'h5A);
        rd_expect(A_RNG, 8'h5A, "R3 range write when off");
        chk({7'b0, vco_sel}, 8'h00, "R4 vco clear");

        // R6 no tracking: lock change ignored
        wr(A_TRK, 8'h00);
        lock = 1'b1;
        settle();
        rd_expect(A_CTRL, 8'h00, "R6 flag untouched");

        // R5/R7 falling edge sets flag with interrupts disabled
        wr(A_TRK, B_AUTO);
        rd_expect(A_TRK, B_AUTO, "R5 track readback");
        lock = 1'b0;
        settle();
        chk({7'b0, irq}, 8'h00, "R7 irq masked");
        rd_expect(A_CTRL, B_FLAG, "R5 falling edge flag");
        rd_expect(A_CTRL, 8'h00, "R8 cleared by read");

        // R7 rising edge with interrupts enabled; R8 write cannot clear
        wr(A_CTRL, B_IE);
        lock = 1'b1;
        settle();
        chk({7'b0, irq}, 8'h01, "R7 irq raised");
        wr(A_CTRL, B_IE);
        chk({7'b0, irq}, 8'h01, "R8 write leaves flag");
        rd_expect(A_CTRL, B_IE | B_FLAG, "R5 rising edge flag");
        chk({7'b0, irq}, 8'h00, "R8 irq after clear");

        // R8 edge in same cycle as clearing read: flag stays set
        @(posedge clk); #1;
        lock = 1'b0;
        @(posedge clk);
        rd_expect(A_CTRL, B_IE, "R8 read during edge");
        chk({7'b0, irq}, 8'h01, "R8 flag kept");
        rd_expect(A_CTRL, B_IE | B_FLAG, "R8 flag kept readback");

        // R9 unmapped addresses
        wr(4'h7, 8'hFF);
        rd_expect(4'h7, 8'h00, "R9 unmapped 7");
        rd_expect(4'hF, 8'h00, "R9 unmapped F");
        rd_expect(A_RNG, 8'h5A, "R9 range untouched");
        rd_expect(A_CTRL, B_IE, "R9 ctrl untouched");

        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            finish_run();
        end
    end

endmodule